// File: doc/BRIEF.md
# Vector Length Calculator

This block turns a vector configuration into the longest vector the hardware can hold, and then grants lengths to setvl requests within that limit. A configuration supplies how many integer and how many floating-point registers each element occupies, how many registers one bank holds, and how many banks exist. When an element uses two or more registers, the registers of one bank are shared among the elements, so the per-bank element count is the bank size divided by one less than the registers used, rounded down. When an element uses fewer than two registers, the whole bank size counts. The per-bank count is multiplied by the number of banks, and the product is capped at the microthread count.

The division runs on a restoring divider, one quotient bit per cycle. A configuration is taken with a one-cycle `cfg_start`. The block holds `cfg_busy` high until the new maximum is stored, and pulses `cfg_done` once the result is valid. A setvl request is a level on `sv_req`, held until `sv_ack`. It is served only while no configuration is running, and the granted length is the smaller of the maximum length and the requested length.

Top module: `vlen_calc`

## Requirements
- R1: When integer plus floating-point registers per element is 0 or 1, the stored maximum length is registers-per-bank times bank count, capped as in R3. The register counts are unsigned.
- R2: When the register sum is 2 or more, the stored maximum length is floor(registers-per-bank / (sum - 1)) times bank count, capped as in R3. A quotient of zero gives a maximum of zero.
- R3: The stored maximum length never exceeds MAX_UTS (default 32). A larger product is replaced by MAX_UTS.
- R4: A setvl request that is accepted makes `sv_ack` high for one cycle, one cycle after acceptance. In that cycle `vl` equals the smaller of `vlmax` and `sv_len`, and `vl` keeps that value until the next grant or reset.
- R5: `cfg_busy` rises in the cycle after an accepted `cfg_start`. It stays high for exactly 1 cycle on the R1 path and for DIV_W+2 cycles (10 at defaults) on the R2 path. It falls in the same cycle in which `cfg_done` is high for one cycle and `vlmax` holds the new value.
- R6: A setvl request is not acknowledged while `cfg_busy` is high, or when it meets an accepted `cfg_start` in the same cycle. If held, it is acknowledged in the cycle after `cfg_done`, against the new maximum length.
- R7: A `cfg_start` that arrives while `cfg_busy` is high is ignored. The running configuration completes with its own result and latency, and no further `cfg_done` follows.
- R8: Synchronous reset clears `vlmax` and `vl` to 0 and drops `cfg_busy`, `cfg_done` and `sv_ack`, including when reset arrives in the middle of a configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start | input | 1 | One-cycle request to compute a new maximum length |
| cfg_int_regs | input | RCNT_W (6) | Integer registers used per element |
| cfg_fp_regs | input | RCNT_W (6) | Floating-point registers used per element |
| cfg_bank_regs | input | RPB_W (8) | Registers per bank |
| cfg_banks | input | BANK_W (4) | Number of banks |
| cfg_busy | output | 1 | Configuration in progress |
| cfg_done | output | 1 | One-cycle pulse: new maximum length stored |
| vlmax | output | LEN_W (6) | Current maximum vector length |
| sv_req | input | 1 | setvl request, held until acknowledged |
| sv_len | input | APP_W (16) | Requested vector length |
| sv_ack | output | 1 | One-cycle setvl acknowledge |
| vl | output | LEN_W (6) | Granted vector length |

## Verification
The assertions assume that the divider is never started with a zero divisor. The top module guarantees this because it only divides when the register sum is at least two. They also assume that `sv_req` is dropped once `sv_ack` has been seen, so each acknowledge relates to a single request. The stimulus changes inputs only on falling edges and releases a request in the same half-cycle in which its acknowledge is observed. The register-count parameters are kept so that the register sum fits the divider width.

// File: rtl/vlen_pkg.sv
package vlen_pkg;

    // Sequencer states of the configuration path
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DIV  = 2'd1,
        ST_FIN  = 2'd2
    } vl_state_e;

    // Larger of two elaboration-time widths
    function automatic int unsigned wmax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/vlen_rdiv.sv
module vlen_rdiv #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quot
);
    localparam int unsigned CNT_W = $clog2(W + 1);

    typedef struct packed {
        logic [W-1:0] rem;
        logic [W-1:0] quo;
    } div_pair_t;

    div_pair_t        cur_q;
    div_pair_t        nxt;
    logic [W-1:0]     dvs_q;
    logic [W-1:0]     dvd_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             done_q;

    // One restoring step: shift in the next dividend bit, trial-subtract
    logic [W:0] shifted;
    logic [W:0] trial;
    always_comb begin
        shifted = {cur_q.rem, cur_q.quo[W-1]};
        trial   = shifted - {1'b0, dvs_q};
        if (trial[W]) begin
            nxt.rem = shifted[W-1:0];
            nxt.quo = {cur_q.quo[W-2:0], 1'b0};
        end else begin
            nxt.rem = trial[W-1:0];
            nxt.quo = {cur_q.quo[W-2:0], 1'b1};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= '0;
            dvs_q  <= '0;
            dvd_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                cur_q.rem <= '0;
                cur_q.quo <= dividend;
                dvs_q     <= divisor;
                dvd_q     <= dividend;
                cnt_q     <= CNT_W'(W);
                busy_q    <= 1'b1;
            end else if (busy_q) begin
                cur_q <= nxt;
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy = busy_q;
    assign done = done_q;
    assign quot = cur_q.quo;

    // Result check: quotient times divisor plus remainder rebuilds the dividend
    logic [2*W-1:0] rebuilt;
    assign rebuilt = (2*W)'(cur_q.quo) * (2*W)'(dvs_q) + (2*W)'(cur_q.rem);

    // R2
    div_identity_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (rebuilt == (2*W)'(dvd_q)) && (cur_q.rem < dvs_q));

    // R2
    div_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> (divisor != '0));

    // R5
    div_restart_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !start);

endmodule

// File: rtl/vlen_scale.sv
module vlen_scale #(
    parameter int unsigned QW      = 8,
    parameter int unsigned BANK_W  = 4,
    parameter int unsigned LEN_W   = 6,
    parameter int unsigned MAX_LEN = 32
) (
    input  logic [QW-1:0]     per_bank,
    input  logic [BANK_W-1:0] banks,
    output logic [LEN_W-1:0]  len_max
);
    localparam int unsigned PW = QW + BANK_W;

    logic [PW-1:0] product;
    assign product = PW'(per_bank) * PW'(banks);

    generate
        if (PW < 32 && ((1 << PW) - 1) <= MAX_LEN) begin : g_nocap
            assign len_max = LEN_W'(product);
        end else begin : g_cap
            localparam int unsigned CW = (PW > LEN_W) ? PW : LEN_W;
            logic [CW-1:0] prod_w;
            assign prod_w  = CW'(product);
            assign len_max = (prod_w > CW'(MAX_LEN)) ? LEN_W'(MAX_LEN) : LEN_W'(prod_w);
        end
    endgenerate

endmodule

// File: rtl/vlen_setvl.sv
module vlen_setvl #(
    parameter int unsigned APP_W = 16,
    parameter int unsigned LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic [APP_W-1:0] len,
    input  logic             stall,
    input  logic [LEN_W-1:0] len_max,
    output logic             ack,
    output logic [LEN_W-1:0] vl
);
    localparam int unsigned CW = (APP_W > LEN_W) ? APP_W : LEN_W;

    logic             accept;
    logic [CW-1:0]    want;
    logic [CW-1:0]    limit;
    logic [LEN_W-1:0] grant;
    logic             ack_q;
    logic [LEN_W-1:0] vl_q;

    assign accept = req && !stall;
    assign want   = CW'(len);
    assign limit  = CW'(len_max);
    assign grant  = (want < limit) ? LEN_W'(want) : len_max;

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q <= 1'b0;
            vl_q  <= '0;
        end else begin
            ack_q <= accept;
            if (accept) begin
                vl_q <= grant;
            end
        end
    end

    assign ack = ack_q;
    assign vl  = vl_q;

    // R4
    grant_bound_chk: assert property (@(posedge clk) disable iff (rst)
        ack |-> (vl <= len_max) && (CW'(vl) <= $past(want)));

    // R4
    grant_tight_chk: assert property (@(posedge clk) disable iff (rst)
        ack |-> (vl == len_max) || (CW'(vl) == $past(want)));

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        stall |=> !ack);

endmodule

// File: rtl/vlen_calc.sv
module vlen_calc
    import vlen_pkg::*;
#(
    parameter int unsigned RCNT_W  = 6,
    parameter int unsigned RPB_W   = 8,
    parameter int unsigned BANK_W  = 4,
    parameter int unsigned APP_W   = 16,
    parameter int unsigned MAX_UTS = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cfg_start,
    input  logic [RCNT_W-1:0]             cfg_int_regs,
    input  logic [RCNT_W-1:0]             cfg_fp_regs,
    input  logic [RPB_W-1:0]              cfg_bank_regs,
    input  logic [BANK_W-1:0]             cfg_banks,
    output logic                          cfg_busy,
    output logic                          cfg_done,
    output logic [$clog2(MAX_UTS+1)-1:0]  vlmax,
    input  logic                          sv_req,
    input  logic [APP_W-1:0]              sv_len,
    output logic                          sv_ack,
    output logic [$clog2(MAX_UTS+1)-1:0]  vl
);
    localparam int unsigned SUM_W = RCNT_W + 1;
    localparam int unsigned DIV_W = wmax(RPB_W, SUM_W);
    localparam int unsigned LEN_W = $clog2(MAX_UTS + 1);

    typedef struct packed {
        logic [SUM_W-1:0]  used;
        logic [RPB_W-1:0]  bank_regs;
        logic [BANK_W-1:0] banks;
    } vl_cfg_t;

    vl_state_e        state_q;
    vl_cfg_t          cfg_q;
    vl_cfg_t          cfg_in;
    logic [LEN_W-1:0] vlmax_q;
    logic             done_q;

    logic             accept;
    logic             need_div;
    logic             div_start;
    logic             div_busy;
    logic             div_done;
    logic [DIV_W-1:0] div_quot;
    logic [DIV_W-1:0] per_bank;
    logic [LEN_W-1:0] scaled;

    assign cfg_in.used      = SUM_W'(cfg_int_regs) + SUM_W'(cfg_fp_regs);
    assign cfg_in.bank_regs = cfg_bank_regs;
    assign cfg_in.banks     = cfg_banks;

    assign accept    = cfg_start && (state_q == ST_IDLE);
    assign need_div  = cfg_in.used >= SUM_W'(2);
    assign div_start = accept && need_div;

    vlen_rdiv #(
        .W (DIV_W)
    ) u_div (
        .clk      (clk),
        .rst      (rst),
        .start    (div_start),
        .dividend (DIV_W'(cfg_in.bank_regs)),
        .divisor  (DIV_W'(cfg_in.used - SUM_W'(1))),
        .busy     (div_busy),
        .done     (div_done),
        .quot     (div_quot)
    );

    // Fewer than two registers per element: the whole bank counts
    assign per_bank = (cfg_q.used < SUM_W'(2)) ? DIV_W'(cfg_q.bank_regs) : div_quot;

    vlen_scale #(
        .QW      (DIV_W),
        .BANK_W  (BANK_W),
        .LEN_W   (LEN_W),
        .MAX_LEN (MAX_UTS)
    ) u_scale (
        .per_bank (per_bank),
        .banks    (cfg_q.banks),
        .len_max  (scaled)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
            vlmax_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (cfg_start) begin
                        cfg_q   <= cfg_in;
                        state_q <= need_div ? ST_DIV : ST_FIN;
                    end
                end
                ST_DIV: begin
                    if (div_done) begin
                        state_q <= ST_FIN;
                    end
                end
                ST_FIN: begin
                    vlmax_q <= scaled;
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign cfg_busy = (state_q != ST_IDLE);
    assign cfg_done = done_q;
    assign vlmax    = vlmax_q;

    vlen_setvl #(
        .APP_W (APP_W),
        .LEN_W (LEN_W)
    ) u_setvl (
        .clk     (clk),
        .rst     (rst),
        .req     (sv_req),
        .len     (sv_len),
        .stall   (cfg_busy || accept),
        .len_max (vlmax_q),
        .ack     (sv_ack),
        .vl      (vl)
    );

    // R3
    cap_limit_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_done |-> (vlmax <= LEN_W'(MAX_UTS)));

    // R7
    ignore_start_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_busy && cfg_start) |=> $stable(cfg_q));

    // R5
    div_tracks_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DIV) |-> (div_busy || div_done));

    // R5
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_done |-> !cfg_busy && $past(cfg_busy));

    // R1
    bypass_fast_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && !need_div) |=> (state_q == ST_FIN));

endmodule

// File: tb/tb_vlen_calc.sv
module tb_vlen_calc;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYCLES = 20000;
    localparam int DIV_LAT = 10;
    localparam int NVEC = 10;

    typedef struct packed {
        int unsigned ni;
        int unsigned nf;
        int unsigned rpb;
        int unsigned banks;
        int unsigned req;
        int unsigned exp_max;
        int unsigned exp_vl;
        int unsigned exp_lat;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{1,  0,   8,  3,    10, 24, 10,  1},
        '{0,  0,  20,  4,   100, 32, 32,  1},
        '{2,  0,  31,  1,    40, 31, 31, 10},
        '{2,  1,  31,  2,    30, 30, 30, 10},
        '{3,  3,  31,  4,     0, 24,  0, 10},
        '{5, 10,  10,  8,     5,  0,  0, 10},
        '{1,  1, 255, 15,    31, 32, 31, 10},
        '{63,63, 255,  1, 65535,  2,  2, 10},
        '{0,  1,   0,  9,     3,  0,  0,  1},
        '{4,  0,   7, 15,    29, 30, 29, 10}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_start;
    logic [5:0]  cfg_int_regs;
    logic [5:0]  cfg_fp_regs;
    logic [7:0]  cfg_bank_regs;
    logic [3:0]  cfg_banks;
    logic        cfg_busy;
    logic        cfg_done;
    logic [5:0]  vlmax;
    logic        sv_req;
    logic [15:0] sv_len;
    logic        sv_ack;
    logic [5:0]  vl;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vlen_calc dut (
        .clk           (clk),
        .rst           (rst),
        .cfg_start     (cfg_start),
        .cfg_int_regs  (cfg_int_regs),
        .cfg_fp_regs   (cfg_fp_regs),
        .cfg_bank_regs (cfg_bank_regs),
        .cfg_banks     (cfg_banks),
        .cfg_busy      (cfg_busy),
        .cfg_done      (cfg_done),
        .vlmax         (vlmax),
        .sv_req        (sv_req),
        .sv_len        (sv_len),
        .sv_ack        (sv_ack),
        .vl            (vl)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Launch a configuration at a falling edge; returns at the negedge where busy is low
    task automatic run_cfg(input int ni, input int nf, input int rpb, input int bk,
                           output int lat);
        cfg_int_regs  = 6'(ni);
        cfg_fp_regs   = 6'(nf);
        cfg_bank_regs = 8'(rpb);
        cfg_banks     = 4'(bk);
        cfg_start     = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cfg_start = 1'b0;
        lat = 0;
        while (cfg_busy && lat < 100) begin
            lat++;
            @(negedge clk);
        end
    endtask

    task automatic run_setvl(input int len);
        sv_len = 16'(len);
        sv_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        sv_req = 1'b0;
    endtask

    initial begin
        repeat (WDOG_CYCLES) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", WDOG_CYCLES, 0);
        summary();
        $finish;
    end

    initial begin
        int lat;
        rst = 1'b1;
        cfg_start = 1'b0;
        cfg_int_regs = '0;
        cfg_fp_regs = '0;
        cfg_bank_regs = '0;
        cfg_banks = '0;
        sv_req = 1'b0;
        sv_len = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R8: reset state
        chk("R8 vlmax", vlmax, 0);
        chk("R8 vl", vl, 0);
        chk("R8 busy", cfg_busy, 0);
        chk("R8 done", cfg_done, 0);
        chk("R8 ack", sv_ack, 0);
        // R4: grant before any configuration is bounded by zero
        run_setvl(5);
        chk("R4 ack", sv_ack, 1);
        chk("R4 vl pre-cfg", vl, 0);

        // Table walk: R1, R2, R3, R4, R5
        for (int i = 0; i < NVEC; i++) begin
            run_cfg(int'(VECS[i].ni), int'(VECS[i].nf), int'(VECS[i].rpb),
                    int'(VECS[i].banks), lat);
            chk((VECS[i].ni + VECS[i].nf < 2) ? "R1 vlmax" : "R2 R3 vlmax",
                vlmax, int'(VECS[i].exp_max));
            chk("R5 latency", lat, int'(VECS[i].exp_lat));
            chk("R5 done", cfg_done, 1);
            run_setvl(int'(VECS[i].req));
            chk("R4 ack", sv_ack, 1);
            chk("R4 vl", vl, int'(VECS[i].exp_vl));
            @(negedge clk);
            chk("R4 ack pulse", sv_ack, 0);
            chk("R4 vl hold", vl, int'(VECS[i].exp_vl));
        end

        // R7: second start during a running division is ignored
        cfg_int_regs  = 6'd2;
        cfg_fp_regs   = 6'd1;
        cfg_bank_regs = 8'd31;
        cfg_banks     = 4'd2;
        cfg_start     = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cfg_start = 1'b0;
        lat = 1;
        repeat (2) begin
            @(negedge clk);
            lat++;
        end
        cfg_int_regs  = 6'd0;
        cfg_fp_regs   = 6'd0;
        cfg_bank_regs = 8'd1;
        cfg_banks     = 4'd1;
        cfg_start     = 1'b1;
        @(negedge clk);
        lat++;
        cfg_start = 1'b0;
        while (cfg_busy && lat < 100) begin
            lat++;
            @(negedge clk);
        end
        lat--;
        chk("R7 latency", lat, DIV_LAT);
        chk("R7 vlmax", vlmax, 30);
        repeat (4) @(negedge clk);
        chk("R7 no extra busy", cfg_busy, 0);
        chk("R7 no extra done", cfg_done, 0);
        chk("R7 vlmax kept", vlmax, 30);

        // R6: setvl raised together with a start is held off, then served with the new maximum
        cfg_int_regs  = 6'd3;
        cfg_fp_regs   = 6'd3;
        cfg_bank_regs = 8'd31;
        cfg_banks     = 4'd4;
        cfg_start     = 1'b1;
        sv_len        = 16'd50;
        sv_req        = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cfg_start = 1'b0;
        lat = 0;
        while (cfg_busy && lat < 100) begin
            chk("R6 stalled ack", sv_ack, 0);
            lat++;
            @(negedge clk);
        end
        chk("R6 done", cfg_done, 1);
        chk("R6 ack after done", sv_ack, 0);
        @(negedge clk);
        chk("R6 ack", sv_ack, 1);
        chk("R6 vl new max", vl, 24);
        sv_req = 1'b0;

        // R8: reset in the middle of a division
        cfg_int_regs  = 6'd2;
        cfg_fp_regs   = 6'd0;
        cfg_bank_regs = 8'd9;
        cfg_banks     = 4'd3;
        cfg_start     = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cfg_start = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 busy before reset", cfg_busy, 1);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R8 mid vlmax", vlmax, 0);
        chk("R8 mid vl", vl, 0);
        chk("R8 mid busy", cfg_busy, 0);
        repeat (12) @(negedge clk);
        chk("R8 no late done", cfg_done, 0);
        chk("R8 vlmax stays", vlmax, 0);

        summary();
        $finish;
    end

endmodule